// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Controller with Software Line Invalidation

This block holds the tag and valid state of two direct-mapped caches for a 32-bit CPU: one for instruction fetches and one for data accesses. Each line covers four 32-bit words. The controller looks up every CPU access and reports whether it is a hit, a miss that needs a line refill, or an access that must go straight to memory. The line data storage, the external memory sequencing and the address decoder are not part of this block. The decoder supplies a region code with each request. The refill engine pulses `refill_done` when a missed line has been fetched.

A two-bit `mode` input, driven from two status-register bits, selects how the block behaves. In mode 00 the caches run normally. In mode 01 ordinary loads and stores become line-invalidate commands. A store clears the instruction line whose number is in the low byte of the store data, and the store still goes to memory. A load or fetch clears the data line that its address indexes, and no memory read takes place. Modes 10 and 11 disable the caches. The arrays come up holding unknown values, so software must sweep every line of both arrays in mode 01 before it selects mode 00. The stored tag leaves out address bits 26:21, so addresses that differ only in those bits alias onto the same entry.

The request side is a valid/ready stream. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read miss waits for its refill. The requester must then hold its request, or withdraw it, until `req_ready` returns. The response side has no back-pressure. Exactly one response is produced for each accepted request, and the consumer must take it in the cycle it appears.

Top module: `cache_tag_ctrl`

## Requirements
- R1: In mode 00, a request in the memory region (`req_region` = 00) looks up the array selected by `req_fetch` (1 = instruction array, 0 = data array). The line index is address bits 11:4 and the tag is address bits 31:27 followed by bits 20:12. A hit requires a valid line whose stored tag equals the request tag. Addresses that differ only in bits 26:21 or bits 3:0 map to the same entry.
- R2: Each accepted request produces exactly one response with `rsp_valid` high in the following cycle. The flags `rsp_hit`, `rsp_miss` and `rsp_mem` are all low whenever `rsp_valid` is low, and `rsp_hit` and `rsp_miss` are never both high.
- R3: In mode 01, an accepted read (load or fetch) clears the valid bit of data-array line address[11:4]. Its response has `rsp_mem`, `rsp_hit` and `rsp_miss` all low.
- R4: In mode 01, an accepted write clears the valid bit of instruction-array line `req_wdata[7:0]`; the upper data bits are ignored. Its response has `rsp_mem` high and `rsp_hit` and `rsp_miss` low.
- R5: In mode 10, and also in mode 11, every response has `rsp_mem` high and `rsp_hit` and `rsp_miss` low. Neither array changes in these modes.
- R6: In mode 00, a request whose region is I/O (01) or unmapped (10 or 11) gets a response with `rsp_mem` high and `rsp_hit` and `rsp_miss` low, and it never allocates a line.
- R7: In mode 00, a memory-region read that misses gets a response with `rsp_miss` and `rsp_mem` high. From that cycle `miss_busy` is high and `req_ready` is low. Both stay that way until a rising edge with `refill_done` high. At that edge the missed line is written with its tag and marked valid, and `miss_busy` falls.
- R8: In mode 00, a memory-region write gets a response with `rsp_mem` high and `rsp_hit` reporting the tag match. It never produces a miss and never allocates a line.
- R9: A `refill_done` pulse while `miss_busy` is low has no effect on either array.
- R10: While reset is asserted and after it is released, `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_mem` and `miss_busy` are low and `req_ready` is high. The arrays are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| mode | input | 2 | Cache mode from the status register: 00 run, 01 invalidate, 10/11 disabled |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load or fetch |
| req_fetch | input | 1 | 1 = instruction fetch (instruction array), 0 = data access |
| req_addr | input | 32 | CPU byte address |
| req_wdata | input | 32 | Store data; low byte names a line in invalidate mode |
| req_region | input | 2 | Region code from the address decoder: 00 memory, 01 I/O, 10/11 unmapped |
| rsp_valid | output | 1 | Response for the request accepted on the previous edge |
| rsp_hit | output | 1 | Tag matched a valid line |
| rsp_miss | output | 1 | Read miss; a refill of the line is required |
| rsp_mem | output | 1 | The access must be carried out on external memory |
| miss_busy | output | 1 | A read miss is waiting for its refill |
| refill_done | input | 1 | Refill of the pending missed line has completed |

## Verification
Each response is due one cycle after its request is accepted. An invalidation, and the tag update triggered by `refill_done`, is visible to a request accepted on the next edge. `miss_busy` and `req_ready` change on the same edge that accepts the miss or the refill. The bench drives inputs on the falling edge and advances a behavioural model by one step for each rising edge. It compares every output on the following falling edge, in every cycle. Mistimed responses, stalls and array updates therefore show up in the exact cycle where they occur.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_FLUSH = 2'b01,
    MODE_OFF   = 2'b10,
    MODE_UNDEF = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    RG_MEM   = 2'b00,
    RG_IO    = 2'b01,
    RG_NOMAP = 2'b10,
    RG_RSVD  = 2'b11
  } region_e;

  typedef struct packed {
    logic hit;
    logic miss;
    logic to_mem;
    logic inval_i;
    logic inval_d;
  } action_t;

endpackage

// File: rtl/ctag_array.sv
module ctag_array #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_vld,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;

  // Storage is not reset: software sweeps every line before enabling.
  always_ff @(posedge clk) begin
    if (set_en) begin
      tag_q[set_idx] <= set_tag;
      vld_q[set_idx] <= 1'b1;
    end
    if (clr_en) begin
      vld_q[clr_idx] <= 1'b0;
    end
  end

  assign lk_tag = tag_q[lk_idx];
  assign lk_vld = vld_q[lk_idx];

  // R9: a refill write and an invalidation never meet in one cycle
  a_r9_set_clr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !clr_en);

endmodule

// File: rtl/ctag_decode.sv
module ctag_decode
  import ctag_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] region,
  input  logic       is_write,
  input  logic       match,
  output action_t    act
);
  mode_e   m;
  region_e r;

  assign m = mode_e'(mode);
  assign r = region_e'(region);

  always_comb begin
    act = '0;
    case (m)
      MODE_RUN: begin
        if (r == RG_MEM) begin
          if (is_write) begin
            act.to_mem = 1'b1;
            act.hit    = match;
          end else if (match) begin
            act.hit = 1'b1;
          end else begin
            act.miss   = 1'b1;
            act.to_mem = 1'b1;
          end
        end else begin
          act.to_mem = 1'b1;
        end
      end
      MODE_FLUSH: begin
        if (is_write) begin
          act.inval_i = 1'b1;
          act.to_mem  = 1'b1;
        end else begin
          act.inval_d = 1'b1;
        end
      end
      default: act.to_mem = 1'b1;
    endcase
  end

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import ctag_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int IDX_W    = 8,
  parameter int IDX_LSB  = 4,
  parameter int TAG_HI_W = 5,
  parameter int TAG_LO_W = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_fetch,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_region,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_miss,
  output logic          rsp_mem,
  output logic          miss_busy,
  input  logic          refill_done
);
  localparam int TAG_W      = TAG_HI_W + TAG_LO_W;
  localparam int TAG_LO_LSB = IDX_LSB + IDX_W;
  localparam int TAG_HI_LSB = AW - TAG_HI_W;
  localparam int N_ARR      = 2;   // 0 = data, 1 = instruction

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic             accept;
  logic             refill_fire;
  logic             match;
  action_t          act;

  logic [N_ARR-1:0][TAG_W-1:0] lk_tag;
  logic [N_ARR-1:0]            lk_vld;
  logic [N_ARR-1:0]            set_en;
  logic [N_ARR-1:0]            clr_en;
  logic [N_ARR-1:0][IDX_W-1:0] clr_idx;

  logic             busy_q;
  logic             miss_fetch_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic [TAG_W-1:0] miss_tag_q;
  logic             rsp_valid_q, rsp_hit_q, rsp_miss_q, rsp_mem_q;

  logic unused_bits;
  assign unused_bits = ^{req_wdata[DW-1:IDX_W], req_addr[IDX_LSB-1:0],
                         req_addr[TAG_HI_LSB-1:TAG_LO_LSB+TAG_LO_W]};

  assign req_idx     = req_addr[IDX_LSB +: IDX_W];
  assign req_tag     = {req_addr[TAG_HI_LSB +: TAG_HI_W], req_addr[TAG_LO_LSB +: TAG_LO_W]};
  assign req_ready   = !busy_q;
  assign accept      = req_valid && req_ready;
  assign refill_fire = refill_done && busy_q;
  assign match       = lk_vld[req_fetch] && (lk_tag[req_fetch] == req_tag);

  assign clr_en[0]  = accept && act.inval_d;
  assign clr_idx[0] = req_idx;
  assign clr_en[1]  = accept && act.inval_i;
  assign clr_idx[1] = req_wdata[IDX_W-1:0];

  for (genvar g = 0; g < N_ARR; g++) begin : g_arr
    assign set_en[g] = refill_fire && (miss_fetch_q == (g == 1));

    ctag_array #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
    ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (req_idx),
      .lk_tag  (lk_tag[g]),
      .lk_vld  (lk_vld[g]),
      .set_en  (set_en[g]),
      .set_idx (miss_idx_q),
      .set_tag (miss_tag_q),
      .clr_en  (clr_en[g]),
      .clr_idx (clr_idx[g])
    );
  end

  ctag_decode u_dec (
    .mode     (mode),
    .region   (req_region),
    .is_write (req_write),
    .match    (match),
    .act      (act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      miss_fetch_q <= 1'b0;
      miss_idx_q   <= '0;
      miss_tag_q   <= '0;
    end else if (accept && act.miss) begin
      busy_q       <= 1'b1;
      miss_fetch_q <= req_fetch;
      miss_idx_q   <= req_idx;
      miss_tag_q   <= req_tag;
    end else if (refill_fire) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_miss_q  <= 1'b0;
      rsp_mem_q   <= 1'b0;
    end else begin
      rsp_valid_q <= accept;
      rsp_hit_q   <= accept && act.hit;
      rsp_miss_q  <= accept && act.miss;
      rsp_mem_q   <= accept && act.to_mem;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_miss  = rsp_miss_q;
  assign rsp_mem   = rsp_mem_q;
  assign miss_busy = busy_q;

  // R2: flags only accompany a response, hit and miss exclusive
  a_r2_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_miss));
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_mem));
  // R7: a reported miss leaves the block waiting for its refill
  a_r7_miss_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> miss_busy);
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_busy && !refill_done) |=> (miss_busy && !rsp_valid));
  // R3: invalidating reads issue no memory access
  a_r3_flush_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b01 && !req_write) |=> (!rsp_mem && !rsp_hit && !rsp_miss));
  // R5: disabled modes always bypass
  a_r5_off_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode[1]) |=> (rsp_mem && !rsp_hit && !rsp_miss));
  // R6: I/O and unmapped regions bypass in run mode
  a_r6_region_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b00 && req_region != 2'b00) |=> (rsp_mem && !rsp_hit && !rsp_miss));

endmodule

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        req_valid, req_ready, req_write, req_fetch;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_region;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_mem, miss_busy, refill_done;

  cache_tag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_region(req_region), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_mem(rsp_mem), .miss_busy(miss_busy),
    .refill_done(refill_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  logic [13:0] m_tag [2][256];
  bit          m_vld [2][256];
  bit          m_busy = 0;
  int          m_arr, m_idx;
  logic [13:0] m_mtag;

  task automatic chk(string rq, string nm, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, nm, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(int hi, int mid, int lo, int ix, int off);
    return {hi[4:0], mid[5:0], lo[8:0], ix[7:0], off[3:0]};
  endfunction

  task automatic cyc(string rq, bit v, bit w, bit f, logic [31:0] a,
                     logic [31:0] wd, logic [1:0] rg, logic [1:0] md, bit rf);
    bit e_v = 0, e_h = 0, e_m = 0, e_mem = 0;
    bit acc;
    int ix, ar;
    logic [13:0] tg;
    bit hitm;
    req_valid = v; req_write = w; req_fetch = f; req_addr = a;
    req_wdata = wd; req_region = rg; mode = md; refill_done = rf;
    acc = v && !m_busy;
    ix  = int'(a[11:4]);
    tg  = {a[31:27], a[20:12]};
    ar  = f ? 1 : 0;
    if (rf && m_busy) begin
      m_tag[m_arr][m_idx] = m_mtag;
      m_vld[m_arr][m_idx] = 1;
      m_busy = 0;
    end
    if (acc) begin
      e_v = 1;
      if (md == 2'b01) begin
        if (w) begin m_vld[1][int'(wd[7:0])] = 0; e_mem = 1; end
        else m_vld[0][ix] = 0;
      end else if (md == 2'b00 && rg == 2'b00) begin
        hitm = m_vld[ar][ix] && (m_tag[ar][ix] == tg);
        if (w) begin e_mem = 1; e_h = hitm; end
        else if (hitm) e_h = 1;
        else begin
          e_m = 1; e_mem = 1;
          m_busy = 1; m_arr = ar; m_idx = ix; m_mtag = tg;
        end
      end else e_mem = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rq, "rsp_valid", rsp_valid, e_v);
    chk(rq, "rsp_hit",   rsp_hit,   e_h);
    chk(rq, "rsp_miss",  rsp_miss,  e_m);
    chk(rq, "rsp_mem",   rsp_mem,   e_mem);
    chk(rq, "miss_busy", miss_busy, m_busy);
    chk(rq, "req_ready", req_ready, !m_busy);
  endtask

  task automatic rd(string rq, bit f, logic [31:0] a, logic [1:0] md);
    cyc(rq, 1, 0, f, a, 32'h0, 2'b00, md, 0);
  endtask

  task automatic idle(string rq, bit rf);
    cyc(rq, 0, 0, 0, 32'h0, 32'h0, 2'b00, 2'b00, rf);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] a_x, a_y;
    rst_n = 0; mode = 2'b10; req_valid = 0; req_write = 0; req_fetch = 0;
    req_addr = 0; req_wdata = 0; req_region = 0; refill_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state during reset
    chk("R10", "rsp_valid", rsp_valid, 0);
    chk("R10", "rsp_mem",   rsp_mem,   0);
    chk("R10", "miss_busy", miss_busy, 0);
    chk("R10", "req_ready", req_ready, 1);
    rst_n = 1;
    idle("R10", 0);

    // R4: sweep instruction lines with junk in the upper data bytes
    for (int i = 0; i < 256; i++)
      cyc("R4", 1, 1, 0, mk(i, i, i, i, 0), {8'hA5, 8'h3C, 8'h77, i[7:0]}, 2'b00, 2'b01, 0);
    // R3: sweep data lines, including fetch-type reads
    for (int i = 0; i < 256; i++)
      cyc("R3", 1, 0, i[0], mk(3, 5, 7, i, 0), 32'h0, 2'b00, 2'b01, 0);

    a_x = mk(2, 0, 9'h1A3, 8'h21, 4);
    // R7: miss, stall with request held, refill, then hit
    rd("R7", 0, a_x, 2'b00);
    rd("R7", 0, a_x, 2'b00);
    rd("R7", 0, a_x, 2'b00);
    idle("R7", 1);
    rd("R1", 0, a_x, 2'b00);
    // R1: aliasing through bits 26:21 and the word offset
    rd("R1", 0, a_x ^ 32'h07E0_0000, 2'b00);
    rd("R1", 0, a_x ^ 32'h0000_000C, 2'b00);
    // R1: different tag bits in 20:12 and 31:27 miss
    rd("R1", 0, a_x ^ 32'h0000_1000, 2'b00);
    idle("R7", 0);
    idle("R7", 1);
    rd("R1", 0, a_x, 2'b00);
    // R1: instruction array is separate
    rd("R1", 1, a_x, 2'b00);
    idle("R7", 1);
    rd("R1", 1, a_x, 2'b00);

    // R8: write hit and write miss without allocation
    cyc("R8", 1, 1, 0, a_x, 32'h1234, 2'b00, 2'b00, 0);
    a_y = mk(9, 1, 9'h044, 8'h77, 0);
    cyc("R8", 1, 1, 0, a_y, 32'h1234, 2'b00, 2'b00, 0);
    rd("R8", 0, a_y, 2'b00);
    idle("R8", 1);

    // R6: I/O and unmapped regions bypass even on cached addresses
    for (int g = 1; g < 4; g++) begin
      cyc("R6", 1, 0, 0, a_x, 32'h0, g[1:0], 2'b00, 0);
      cyc("R6", 1, 0, 0, mk(20, 2, 3, 8'h99, 0), 32'h0, g[1:0], 2'b00, 0);
    end
    rd("R6", 0, mk(20, 2, 3, 8'h99, 0), 2'b00);
    idle("R6", 1);

    // R5: disabled modes bypass and leave the arrays alone
    rd("R5", 0, a_x, 2'b10);
    rd("R5", 0, a_x, 2'b11);
    cyc("R5", 1, 1, 0, a_x, 32'h21, 2'b00, 2'b11, 0);
    rd("R5", 0, a_x, 2'b00);
    rd("R5", 1, a_x, 2'b00);

    // R3 and R4: targeted invalidation, then observe the misses
    rd("R3", 1, a_x, 2'b01);
    rd("R3", 0, a_x, 2'b00);
    idle("R3", 1);
    cyc("R4", 1, 1, 0, 32'h0, 32'hFFFF_FF21, 2'b00, 2'b01, 0);
    rd("R4", 1, a_x, 2'b00);
    idle("R4", 1);

    // R9: stray refill pulses leave an invalid line invalid
    rd("R9", 0, mk(1, 1, 1, 8'h55, 0), 2'b01);
    idle("R9", 1);
    idle("R9", 1);
    rd("R9", 0, mk(1, 1, 1, 8'h55, 0), 2'b00);
    idle("R9", 1);

    // R2: mixed traffic over a small address pool
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      logic [1:0] md = (r < 70) ? 2'b00 : (r < 82) ? 2'b01 : r[1:0] | 2'b10;
      logic [1:0] rg = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      logic [31:0] a = mk($urandom_range(0, 1), $urandom_range(0, 2),
                          $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 15));
      cyc("R2", $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
          $urandom_range(0, 1), a, 32'($urandom_range(0, 3)), rg, md,
          $urandom_range(0, 2) == 0);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule